// File: doc/BRIEF.md
# Accumulator and Temp Register Execution Unit

This unit carries out a small family of one-byte register instructions on a 16-bit accumulator (A) and a 16-bit temporary register (T), both held inside the unit. It covers add-with-carry and subtract-with-borrow at byte and word width, exchanges of A with T, and exchanges of A with the stack pointer, index and extra pointer registers. It also covers copying the program counter into A. The pointer registers and the program counter sit outside the unit. Their current values come in on input ports. A write-back strobe and the old accumulator value go out, so the owner of each register can complete an exchange. The carry used by an arithmetic instruction arrives on `carry_in`. The unit keeps its own registered N, Z, V and C flags, and only the four arithmetic instructions update them.

A surrounding sequencer presents an opcode together with a one-cycle `start`. The unit has two states. In `ST_IDLE` it accepts `start`. Every instruction except the program-counter copy commits at that clock edge and pulses `done`, and the unit stays in `ST_IDLE`. The program-counter copy takes the transition `ST_IDLE -> ST_PC_FETCH`. At the following edge it writes A, pulses `done` and takes `ST_PC_FETCH -> ST_IDLE`. While the unit is idle and `start` is low, the load strobes `ld_a` and `ld_t` write `ld_data` into A or T. This is how the datapath around the unit sets up operands.

Top module: `acc_tmp_exec`

## Requirements
- R1: A synchronous reset (`rst` high) clears A, T, all four flags, `done`, `illegal`, `exch_we` and `exch_wdata`, and the unit returns to `ST_IDLE`.
- R2: Opcode 0x22 sets A[7:0] to A[7:0] + T[7:0] + carry_in, keeps A[15:8], sets C to the carry out of bit 7, and leaves T unchanged.
- R3: Opcode 0x23 sets A to A + T + carry_in over 16 bits and sets C to the carry out of bit 15.
- R4: Opcode 0x32 sets A[7:0] to T[7:0] − A[7:0] − carry_in, so T is the minuend. It keeps A[15:8] and sets C when the subtraction borrows.
- R5: Opcode 0x33 sets A to T − A − carry_in over 16 bits and sets C when the subtraction borrows.
- R6: For the four arithmetic opcodes, N is the result bit at the top of the operation width (bit 7 or bit 15). Z is 1 when the result at that width is zero. V is 1 when the signed two's-complement result does not fit that width.
- R7: Opcode 0x42 swaps A[7:0] with T[7:0] and leaves both upper bytes alone. Opcode 0x43 swaps all 16 bits of A and T.
- R8: Opcodes 0xF5, 0xF6 and 0xF7 load A from `sp_in`, `ix_in` and `ep_in` respectively. In the `done` cycle they drive the old A on `exch_wdata` and raise `exch_we` bit 0 (stack pointer), bit 1 (index) or bit 2 (extra pointer). `exch_we` is zero in every other cycle.
- R9: Opcode 0xF0 loads A from `pc_in` as sampled at the second clock edge after `start`. `done` rises only after that edge, two cycles after `start`.
- R10: Exchanges, the program-counter copy and unsupported opcodes leave N, Z, V and C unchanged.
- R11: Any opcode outside {0x22, 0x23, 0x32, 0x33, 0x42, 0x43, 0xF0, 0xF5, 0xF6, 0xF7} changes neither A nor T. It raises `illegal` together with a one-cycle `done`.
- R12: For every opcode except 0xF0, `done` is high in the cycle right after the `start` edge and low again after that unless `start` repeats. A `start` seen in `ST_PC_FETCH` is ignored.
- R13: In `ST_IDLE` with `start` low, `ld_a` and `ld_t` write `ld_data` into A and T. When `start` is high the load strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin the instruction on `opcode` |
| opcode | input | 8 | Instruction code |
| carry_in | input | 1 | Carry consumed by the arithmetic instructions |
| ld_a | input | 1 | Write `ld_data` into A while idle |
| ld_t | input | 1 | Write `ld_data` into T while idle |
| ld_data | input | 16 | Operand load value |
| sp_in | input | 16 | Current stack pointer |
| ix_in | input | 16 | Current index register |
| ep_in | input | 16 | Current extra pointer |
| pc_in | input | 16 | Current program counter |
| a_out | output | 16 | Accumulator |
| t_out | output | 16 | Temporary register |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Signed overflow flag |
| flag_c | output | 1 | Carry / borrow flag |
| done | output | 1 | Instruction complete, one cycle |
| illegal | output | 1 | Unsupported opcode, with `done` |
| exch_we | output | 3 | Write strobe: bit 0 SP, bit 1 IX, bit 2 EP |
| exch_wdata | output | 16 | Old A value for the pointer write-back |

## Verification
A one-cycle instruction commits A, T, the flags, `done`, `illegal` and the exchange strobe at the first rising edge after `start`. The bench drives `start` at a falling edge and releases it at the next falling edge, then samples every result at that same falling edge, half a cycle after the commit. For 0xF0 it samples once after the first edge, where `done` must still be low, and once more after the second edge, where A must equal `pc_in`. Operands are set with the load strobes beforehand. The previous flag values are captured before each instruction so that flags which must hold can be compared directly. Expected results come from integer arithmetic in the bench over grids of byte and word operands with both carry values, and the bench also sweeps all 256 opcodes for the unsupported-opcode case.

// File: rtl/acc_exec_pkg.sv
package acc_exec_pkg;

    typedef enum logic [0:0] {
        ST_IDLE,
        ST_PC_FETCH
    } exec_state_e;

    typedef enum logic [3:0] {
        OPK_ADD_B,
        OPK_ADD_W,
        OPK_SUB_B,
        OPK_SUB_W,
        OPK_SWAP_B,
        OPK_SWAP_W,
        OPK_XSP,
        OPK_XIX,
        OPK_XEP,
        OPK_PC,
        OPK_BAD
    } op_kind_e;

    localparam logic [7:0] OPC_ADD_B  = 8'h22;
    localparam logic [7:0] OPC_ADD_W  = 8'h23;
    localparam logic [7:0] OPC_SUB_B  = 8'h32;
    localparam logic [7:0] OPC_SUB_W  = 8'h33;
    localparam logic [7:0] OPC_SWAP_B = 8'h42;
    localparam logic [7:0] OPC_SWAP_W = 8'h43;
    localparam logic [7:0] OPC_PC     = 8'hF0;
    localparam logic [7:0] OPC_XSP    = 8'hF5;
    localparam logic [7:0] OPC_XIX    = 8'hF6;
    localparam logic [7:0] OPC_XEP    = 8'hF7;

    localparam int unsigned PTR_SP = 0;
    localparam int unsigned PTR_IX = 1;
    localparam int unsigned PTR_EP = 2;
    localparam int unsigned PTR_N  = 3;

endpackage

// File: rtl/acc_exec_decode.sv
module acc_exec_decode
    import acc_exec_pkg::*;
(
    input  logic [7:0] opcode,
    output op_kind_e   kind
);

    always_comb begin
        case (opcode)
            OPC_ADD_B:  kind = OPK_ADD_B;
            OPC_ADD_W:  kind = OPK_ADD_W;
            OPC_SUB_B:  kind = OPK_SUB_B;
            OPC_SUB_W:  kind = OPK_SUB_W;
            OPC_SWAP_B: kind = OPK_SWAP_B;
            OPC_SWAP_W: kind = OPK_SWAP_W;
            OPC_PC:     kind = OPK_PC;
            OPC_XSP:    kind = OPK_XSP;
            OPC_XIX:    kind = OPK_XIX;
            OPC_XEP:    kind = OPK_XEP;
            default:    kind = OPK_BAD;
        endcase
    end

endmodule

// File: rtl/acc_exec_alu.sv
module acc_exec_alu #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] acc,
    input  logic [W-1:0] tmp,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         n,
    output logic         z,
    output logic         v,
    output logic         c
);

    logic [W:0] ext;
    logic [W:0] cin_ext;

    assign cin_ext = {{W{1'b0}}, cin};

    always_comb begin
        if (sub) begin
            ext = {1'b0, tmp} - {1'b0, acc} - cin_ext;
            v   = (tmp[W-1] != acc[W-1]) && (ext[W-1] != tmp[W-1]);
        end else begin
            ext = {1'b0, acc} + {1'b0, tmp} + cin_ext;
            v   = (tmp[W-1] == acc[W-1]) && (ext[W-1] != acc[W-1]);
        end
        res = ext[W-1:0];
        c   = ext[W];
        n   = ext[W-1];
        z   = (ext[W-1:0] == '0);
    end

endmodule

// File: rtl/acc_tmp_exec.sv
module acc_tmp_exec
    import acc_exec_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic              carry_in,
    input  logic              ld_a,
    input  logic              ld_t,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [DATA_W-1:0] sp_in,
    input  logic [DATA_W-1:0] ix_in,
    input  logic [DATA_W-1:0] ep_in,
    input  logic [DATA_W-1:0] pc_in,
    output logic [DATA_W-1:0] a_out,
    output logic [DATA_W-1:0] t_out,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_v,
    output logic              flag_c,
    output logic              done,
    output logic              illegal,
    output logic [PTR_N-1:0]  exch_we,
    output logic [DATA_W-1:0] exch_wdata
);

    localparam int unsigned HALF_W = DATA_W / 2;

    exec_state_e state_q, state_d;
    op_kind_e    kind;

    logic [DATA_W-1:0] a_q, t_q, exch_wdata_q;
    logic              n_q, z_q, v_q, c_q;
    logic              done_q, illegal_q;
    logic [PTR_N-1:0]  exch_we_q;

    logic [HALF_W-1:0] rb;
    logic              nb, zb, vb, cb;
    logic [DATA_W-1:0] rw;
    logic              nw, zw, vw, cw;
    logic              accept;

    acc_exec_decode u_dec (
        .opcode (opcode),
        .kind   (kind)
    );

    acc_exec_alu #(.W(HALF_W)) u_alu_b (
        .acc (a_q[HALF_W-1:0]),
        .tmp (t_q[HALF_W-1:0]),
        .cin (carry_in),
        .sub (kind == OPK_SUB_B),
        .res (rb), .n (nb), .z (zb), .v (vb), .c (cb)
    );

    acc_exec_alu #(.W(DATA_W)) u_alu_w (
        .acc (a_q),
        .tmp (t_q),
        .cin (carry_in),
        .sub (kind == OPK_SUB_W),
        .res (rw), .n (nw), .z (zw), .v (vw), .c (cw)
    );

    assign accept = (state_q == ST_IDLE) && start;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start && kind == OPK_PC) state_d = ST_PC_FETCH;
            ST_PC_FETCH: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Datapath, flags and output strobes
    always_ff @(posedge clk) begin
        if (rst) begin
            a_q          <= '0;
            t_q          <= '0;
            {n_q, z_q, v_q, c_q} <= 4'b0000;
            done_q       <= 1'b0;
            illegal_q    <= 1'b0;
            exch_we_q    <= '0;
            exch_wdata_q <= '0;
        end else begin
            done_q    <= 1'b0;
            illegal_q <= 1'b0;
            exch_we_q <= '0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        done_q <= (kind != OPK_PC);
                        case (kind)
                            OPK_ADD_B, OPK_SUB_B: begin
                                a_q[HALF_W-1:0]      <= rb;
                                {n_q, z_q, v_q, c_q} <= {nb, zb, vb, cb};
                            end
                            OPK_ADD_W, OPK_SUB_W: begin
                                a_q                  <= rw;
                                {n_q, z_q, v_q, c_q} <= {nw, zw, vw, cw};
                            end
                            OPK_SWAP_B: begin
                                a_q[HALF_W-1:0] <= t_q[HALF_W-1:0];
                                t_q[HALF_W-1:0] <= a_q[HALF_W-1:0];
                            end
                            OPK_SWAP_W: begin
                                a_q <= t_q;
                                t_q <= a_q;
                            end
                            OPK_XSP: begin
                                a_q               <= sp_in;
                                exch_wdata_q      <= a_q;
                                exch_we_q[PTR_SP] <= 1'b1;
                            end
                            OPK_XIX: begin
                                a_q               <= ix_in;
                                exch_wdata_q      <= a_q;
                                exch_we_q[PTR_IX] <= 1'b1;
                            end
                            OPK_XEP: begin
                                a_q               <= ep_in;
                                exch_wdata_q      <= a_q;
                                exch_we_q[PTR_EP] <= 1'b1;
                            end
                            OPK_PC: ;
                            default: illegal_q <= 1'b1;
                        endcase
                    end else begin
                        if (ld_a) a_q <= ld_data;
                        if (ld_t) t_q <= ld_data;
                    end
                end
                ST_PC_FETCH: begin
                    a_q    <= pc_in;
                    done_q <= 1'b1;
                end
            endcase
        end
    end

    assign a_out      = a_q;
    assign t_out      = t_q;
    assign flag_n     = n_q;
    assign flag_z     = z_q;
    assign flag_v     = v_q;
    assign flag_c     = c_q;
    assign done       = done_q;
    assign illegal    = illegal_q;
    assign exch_we    = exch_we_q;
    assign exch_wdata = exch_wdata_q;

    // Byte arithmetic keeps the upper accumulator byte (R2, R4)
    assert_byte_keeps_high_R2: assert property (@(posedge clk) disable iff (rst)
        (accept && (kind == OPK_ADD_B || kind == OPK_SUB_B))
        |=> (a_q[DATA_W-1:HALF_W] == $past(a_q[DATA_W-1:HALF_W])));

    // Non-arithmetic instructions leave flags alone (R10)
    assert_flags_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (accept && !(kind inside {OPK_ADD_B, OPK_ADD_W, OPK_SUB_B, OPK_SUB_W}))
        |=> $stable({n_q, z_q, v_q, c_q}));

    assert_pc_flags_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PC_FETCH) |=> $stable({n_q, z_q, v_q, c_q}));

    // One-cycle completion (R12)
    assert_done_one_cycle_R12: assert property (@(posedge clk) disable iff (rst)
        (accept && kind != OPK_PC) |=> done_q);

    // Program-counter copy takes two edges (R9)
    assert_pc_first_edge_R9: assert property (@(posedge clk) disable iff (rst)
        (accept && kind == OPK_PC) |=> (!done_q && state_q == ST_PC_FETCH));

    assert_pc_second_edge_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PC_FETCH) |=> (done_q && a_q == $past(pc_in)));

    // Unsupported opcode flagged together with done (R11)
    assert_illegal_with_done_R11: assert property (@(posedge clk) disable iff (rst)
        illegal_q |-> done_q);

    // Pointer write strobe: at most one bit, only with done (R8)
    assert_exch_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(exch_we_q) && ((exch_we_q != '0) -> done_q));

endmodule

// File: tb/test_acc_tmp_exec.sv
module test_acc_tmp_exec;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic        carry_in = 1'b0;
    logic        ld_a = 1'b0, ld_t = 1'b0;
    logic [15:0] ld_data = '0;
    logic [15:0] sp_in = 16'h1357, ix_in = 16'h2468, ep_in = 16'h9ABC, pc_in = 16'hC0DE;
    logic [15:0] a_out, t_out, exch_wdata;
    logic        flag_n, flag_z, flag_v, flag_c, done, illegal;
    logic [2:0]  exch_we;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    acc_tmp_exec i_acc_tmp_exec (
        .clk, .rst, .start, .opcode, .carry_in, .ld_a, .ld_t, .ld_data,
        .sp_in, .ix_in, .ep_in, .pc_in, .a_out, .t_out,
        .flag_n, .flag_z, .flag_v, .flag_c, .done, .illegal,
        .exch_we, .exch_wdata
    );

    function automatic logic [3:0] flags();
        return {flag_n, flag_z, flag_v, flag_c};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [15:0] a, input logic [15:0] t);
        @(negedge clk); ld_a = 1'b1; ld_data = a;
        @(negedge clk); ld_a = 1'b0; ld_t = 1'b1; ld_data = t;
        @(negedge clk); ld_t = 1'b0;
    endtask

    // Issue one instruction; returns after the commit, sampled at a falling edge
    task automatic issue(input logic [7:0] op, input logic c);
        @(negedge clk); opcode = op; carry_in = c; start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    // Reference arithmetic on integers
    task automatic ref_arith(input int w, input bit sub, input logic [15:0] a,
                             input logic [15:0] t, input bit c,
                             output logic [15:0] a_new, output logic [3:0] fl);
        int mask, ua, ut, r, sa, st, sr, half, res;
        bit n, z, v, cy;
        mask = (1 << w) - 1;
        half = 1 << (w - 1);
        ua = int'(a) & mask;
        ut = int'(t) & mask;
        sa = (ua >= half) ? ua - (1 << w) : ua;
        st = (ut >= half) ? ut - (1 << w) : ut;
        if (sub) begin r = ut - ua - int'(c); sr = st - sa - int'(c); cy = (r < 0); end
        else     begin r = ua + ut + int'(c); sr = sa + st + int'(c); cy = (r > mask); end
        res = r & mask;
        v = (sr > half - 1) || (sr < -half);
        n = ((res >> (w - 1)) & 1) != 0;
        z = (res == 0);
        a_new = (w == 8) ? {a[15:8], 8'(res)} : 16'(res);
        fl = {n, z, v, cy};
    endtask

    function automatic logic [15:0] word_val(input int i);
        case (i)
            0: return 16'h0000;  1: return 16'h0001;  2: return 16'h7FFF;
            3: return 16'h8000;  4: return 16'hFFFF;  5: return 16'h1234;
            6: return 16'hABCD;  7: return 16'h00FF;  8: return 16'hFF00;
            9: return 16'h5555; 10: return 16'hAAAA; default: return 16'h8001;
        endcase
    endfunction

    function automatic bit is_legal(input logic [7:0] op);
        return op inside {8'h22, 8'h23, 8'h32, 8'h33, 8'h42, 8'h43,
                          8'hF0, 8'hF5, 8'hF6, 8'hF7};
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] a_exp, av, tv;
        logic [3:0]  f_exp, f_prev;

        repeat (3) @(negedge clk);
        ld_a = 1'b1; ld_data = 16'hFFFF;
        @(negedge clk); rst = 1'b0; ld_a = 1'b0;
        // R1: state after reset (load was held off by reset)
        chk("R1 a", 32'(a_out), 0);
        chk("R1 t", 32'(t_out), 0);
        chk("R1 flags", 32'(flags()), 0);
        chk("R1 strobes", 32'({done, illegal, exch_we}), 0);
        chk("R1 wdata", 32'(exch_wdata), 0);

        // R2 R4 R6: byte arithmetic sweep
        for (int ai = 0; ai < 16; ai++) begin
            for (int ti = 0; ti < 16; ti++) begin
                for (int c = 0; c < 2; c++) begin
                    for (int s = 0; s < 2; s++) begin
                        av = {8'(ai * 13 + 5), 8'(ai * 17)};
                        tv = {8'(ti * 7 + 1), 8'(ti * 17)};
                        load(av, tv);
                        ref_arith(8, s[0], av, tv, c[0], a_exp, f_exp);
                        issue(s[0] ? 8'h32 : 8'h22, c[0]);
                        chk(s[0] ? "R4 a" : "R2 a", 32'(a_out), 32'(a_exp));
                        chk("R6 byte flags", 32'(flags()), 32'(f_exp));
                        chk("R12 done", 32'(done), 1);
                        chk(s[0] ? "R4 t" : "R2 t", 32'(t_out), 32'(tv));
                    end
                end
            end
        end

        // R3 R5 R6: word arithmetic sweep
        for (int ai = 0; ai < 12; ai++) begin
            for (int ti = 0; ti < 12; ti++) begin
                for (int c = 0; c < 2; c++) begin
                    for (int s = 0; s < 2; s++) begin
                        av = word_val(ai);
                        tv = word_val(ti);
                        load(av, tv);
                        ref_arith(16, s[0], av, tv, c[0], a_exp, f_exp);
                        issue(s[0] ? 8'h33 : 8'h23, c[0]);
                        chk(s[0] ? "R5 a" : "R3 a", 32'(a_out), 32'(a_exp));
                        chk("R6 word flags", 32'(flags()), 32'(f_exp));
                    end
                end
            end
        end

        // Give flags a non-zero pattern: 0x7FFF + 0x0001 -> N=1 V=1
        load(16'h7FFF, 16'h0001);
        issue(8'h23, 1'b0);
        f_prev = flags();
        chk("R6 setup", 32'(f_prev), 32'(4'b1010));

        // R7: byte and word swaps
        load(16'hA1B2, 16'hC3D4);
        issue(8'h42, 1'b1);
        chk("R7 byte swap a", 32'(a_out), 32'h0000A1D4);
        chk("R7 byte swap t", 32'(t_out), 32'h0000C3B2);
        chk("R10 flags after 42", 32'(flags()), 32'(f_prev));
        issue(8'h43, 1'b0);
        chk("R7 word swap a", 32'(a_out), 32'h0000C3B2);
        chk("R7 word swap t", 32'(t_out), 32'h0000A1D4);
        chk("R10 flags after 43", 32'(flags()), 32'(f_prev));

        // R8: pointer exchanges
        for (int k = 0; k < 3; k++) begin
            logic [15:0] src;
            load(16'h4000 + 16'(k), 16'h0000);
            src = (k == 0) ? sp_in : (k == 1) ? ix_in : ep_in;
            issue(8'hF5 + 8'(k), 1'b0);
            chk("R8 a", 32'(a_out), 32'(src));
            chk("R8 we", 32'(exch_we), 32'(3'b001 << k));
            chk("R8 wdata", 32'(exch_wdata), 32'h4000 + k);
            chk("R10 flags after exch", 32'(flags()), 32'(f_prev));
            @(negedge clk);
            chk("R8 we drop", 32'(exch_we), 0);
        end

        // R9: program-counter copy, two cycles
        load(16'h0F0F, 16'h0000);
        @(negedge clk); opcode = 8'hF0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R9 no done at first edge", 32'(done), 0);
        chk("R9 a not yet written", 32'(a_out), 32'h0F0F);
        @(negedge clk);
        chk("R9 done", 32'(done), 1);
        chk("R9 a", 32'(a_out), 32'(pc_in));
        chk("R10 flags after F0", 32'(flags()), 32'(f_prev));

        // R12: start during PC_FETCH ignored
        pc_in = 16'h5A5A;
        load(16'h0001, 16'h0001);
        @(negedge clk); opcode = 8'hF0; start = 1'b1;
        @(negedge clk); opcode = 8'h23;
        @(negedge clk); start = 1'b0;
        chk("R12 busy a", 32'(a_out), 32'h5A5A);
        chk("R12 busy done", 32'(done), 1);
        @(negedge clk);
        chk("R12 busy no second done", 32'(done), 0);
        chk("R12 busy a held", 32'(a_out), 32'h5A5A);
        chk("R12 busy flags", 32'(flags()), 32'(f_prev));

        // R13: load ignored when start is high
        load(16'h1111, 16'h2222);
        chk("R13 load a", 32'(a_out), 32'h1111);
        chk("R13 load t", 32'(t_out), 32'h2222);
        @(negedge clk); opcode = 8'h43; start = 1'b1; ld_a = 1'b1; ld_data = 16'h9999;
        @(negedge clk); start = 1'b0; ld_a = 1'b0;
        chk("R13 load blocked a", 32'(a_out), 32'h2222);
        chk("R13 load blocked t", 32'(t_out), 32'h1111);

        // R11: sweep every unsupported opcode
        for (int op = 0; op < 256; op++) begin
            if (!is_legal(8'(op))) begin
                load(16'h3C3C, 16'hC3C3);
                issue(8'(op), 1'b1);
                chk("R11 illegal", 32'(illegal), 1);
                chk("R11 done", 32'(done), 1);
                chk("R11 a", 32'(a_out), 32'h3C3C);
                chk("R11 t", 32'(t_out), 32'hC3C3);
                chk("R11 exch_we", 32'(exch_we), 0);
                chk("R10 flags illegal", 32'(flags()), 32'(f_prev));
            end
        end
        issue(8'h43, 1'b0);
        chk("R11 legal not flagged", 32'(illegal), 0);
        @(negedge clk);
        chk("R12 done drops", 32'(done), 0);

        // R1: reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 a after reset", 32'(a_out), 0);
        chk("R1 flags after reset", 32'(flags()), 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule